// File: doc/BRIEF.md
# Palette colour-map register block

This block holds the colour map of an indexed-colour frame buffer. It stores 256 main entries, one for each 8-bit pixel value, and a bank of 4 overlay entries that a hardware cursor uses. Each entry has an 8-bit red, an 8-bit green and an 8-bit blue component. Software programs the map through a 32-bit register port. It first writes an entry number to the index register. It then streams the components through a data register, always in the order red, green, blue. After each blue access the entry number moves on by one, so a whole table loads as one long stream of writes.

A second data address sends the same stream into the overlay bank, which sits directly above the main entries. Reads step through the same red, green, blue sequence, so software reads a table back the same way it loads it. A separate combinational lookup port turns an entry number into a packed 24-bit colour for the pixel pipeline. Words 0 to 3 of the register window hold the index register, the main data register, an unused control word and the overlay data register.

Top module: `pal_ctl`

## Requirements
- R1: After synchronous reset every component of every entry is 0, except entries 255, 256 and 258, which read as {FF,FF,FF}. The entry index and the component phase are both 0, and phase 0 means red.
- R2: A full-width write to byte offset 0 loads the entry index from write data bits 31:24 and sets the phase to red.
- R3: A full-width write to byte offset 4 stores write data bits 31:24 into the current component of main entry [index], and bits 23:0 are ignored. The phase runs red, then green, then blue. After the blue write the phase returns to red and the index increments modulo 256, so 255 wraps to 0.
- R4: A full-width write to byte offset 12 stores the component into overlay entry 256 + (index mod 4) instead. It uses the same phase sequence and the same index increment.
- R5: A full-width read at any aligned offset returns the current component of main entry [index] in bits 31:24 of `bus_rdata`, with bits 23:0 zero. The value appears on the clock edge that takes the request. A read advances the phase and index exactly as a data write does, and it changes no entry.
- R6: `lut_rgb` shows {red, green, blue} of entry `lut_idx` combinationally, with red in bits 23:16. An index of 260 or more returns 0. A write becomes visible on `lut_rgb` right after the clock edge that takes it.
- R7: An access whose byte enables are not all ones changes no entry, no index and no phase. A read of that kind returns 0.
- R8: A write to byte offset 8, or to any address with bits 1:0 not zero, changes no entry, no index and no phase. A read at an unaligned address returns 0 and does not advance.
- R9: A write to the index register in the middle of a component sequence restarts the sequence at red, on the newly loaded entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset within the register window |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, held until the next read |
| lut_idx | input | 9 | Entry number for the lookup port |
| lut_rgb | output | 24 | {red, green, blue} of entry `lut_idx` |

## Verification
The bench builds the block with its default parameters: 256 main entries and 4 overlay entries. With these values the index wrap from 255 back to 0 can be reached, and so can the overlay alias in which index 7 selects entry 259 and index 5 selects entry 257. The same values put the reset-white entries at the main/overlay boundary, and they leave a lookup range above 259 that must read as 0.

// File: rtl/pal_pkg.sv
package pal_pkg;

    localparam int ADDR_W = 4;
    localparam int COMP_W = 8;

    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2
    } phase_t;

    typedef enum logic [1:0] {
        W_INDEX = 2'd0,
        W_MAIN  = 2'd1,
        W_CTRL  = 2'd2,
        W_OVL   = 2'd3
    } word_t;

    typedef struct packed {
        logic [COMP_W-1:0] r;
        logic [COMP_W-1:0] g;
        logic [COMP_W-1:0] b;
    } rgb_t;

    // Reset colour: the last main entry plus overlay 0 and overlay 2 are white.
    function automatic rgb_t reset_rgb(int unsigned idx, int unsigned nmain);
        rgb_t c;
        c = '0;
        if (idx == nmain - 1 || idx == nmain || idx == nmain + 2)
            c = '{r: '1, g: '1, b: '1};
        return c;
    endfunction

    function automatic logic [COMP_W-1:0] pick(rgb_t c, phase_t p);
        logic [COMP_W-1:0] v;
        case (p)
            PH_RED:  v = c.r;
            PH_GRN:  v = c.g;
            default: v = c.b;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/pal_seq.sv
module pal_seq
    import pal_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [IDX_W-1:0] load_val,
    input  logic             step,
    output logic [IDX_W-1:0] idx,
    output phase_t           phase
);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx   <= '0;
            phase <= PH_RED;
        end else if (load) begin
            idx   <= load_val;
            phase <= PH_RED;
        end else if (step) begin
            case (phase)
                PH_RED: phase <= PH_GRN;
                PH_GRN: phase <= PH_BLU;
                default: begin
                    phase <= PH_RED;
                    idx   <= idx + 1'b1;
                end
            endcase
        end
    end

    // R2 / R9: an index load restarts the sequence at red
    a_r2_load_restarts: assert property (@(posedge clk) disable iff (rst)
        load |=> (idx == $past(load_val)) && (phase == PH_RED));

    // R3: a step past blue wraps the phase and bumps the index
    a_r3_blue_wraps: assert property (@(posedge clk) disable iff (rst)
        (step && !load && phase == PH_BLU) |=>
            (phase == PH_RED) && (idx == IDX_W'($past(idx) + 1'b1)));

    // R7: with no request the sequencer state stays put
    a_r7_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!step && !load) |=> $stable(idx) && $stable(phase));

endmodule

// File: rtl/pal_store.sv
module pal_store
    import pal_pkg::*;
#(
    parameter int NUM_MAIN = 256,
    parameter int NUM_OVL  = 4,
    localparam int TOT     = NUM_MAIN + NUM_OVL,
    localparam int SEL_W   = $clog2(TOT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [SEL_W-1:0]  wsel,
    input  phase_t            wphase,
    input  logic [COMP_W-1:0] wbyte,
    input  logic [SEL_W-1:0]  rsel,
    output rgb_t              rrgb,
    input  logic [SEL_W-1:0]  lut_sel,
    output rgb_t              lut_rgb
);

    rgb_t ent [TOT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < TOT; e++)
                ent[e] <= reset_rgb(e, NUM_MAIN);
        end else if (we && int'(wsel) < TOT) begin
            case (wphase)
                PH_RED:  ent[wsel].r <= wbyte;
                PH_GRN:  ent[wsel].g <= wbyte;
                default: ent[wsel].b <= wbyte;
            endcase
        end
    end

    always_comb begin
        rrgb    = (int'(rsel) < TOT)    ? ent[rsel]    : '0;
        lut_rgb = (int'(lut_sel) < TOT) ? ent[lut_sel] : '0;
    end

    // R3 / R4: the addressed component holds the written byte afterwards
    a_r3_write_lands: assert property (@(posedge clk) disable iff (rst)
        (we && int'(wsel) < TOT) |=>
            pick(ent[$past(wsel)], $past(wphase)) == $past(wbyte));

endmodule

// File: rtl/pal_ctl.sv
module pal_ctl
    import pal_pkg::*;
#(
    parameter int NUM_MAIN = 256,
    parameter int NUM_OVL  = 4,
    parameter int DW       = 32,
    localparam int SEL_W   = $clog2(NUM_MAIN + NUM_OVL)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW/8-1:0]   bus_be,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [SEL_W-1:0]  lut_idx,
    output logic [3*COMP_W-1:0] lut_rgb
);

    localparam int IDX_W = $clog2(NUM_MAIN);
    localparam int OVL_W = $clog2(NUM_OVL);

    word_t             word;
    logic              acc, do_load, do_wdata, do_read;
    logic [IDX_W-1:0]  idx;
    phase_t            phase;
    logic [SEL_W-1:0]  wsel;
    rgb_t              rd_rgb, lut_c;

    always_comb begin
        word     = word_t'(bus_addr[3:2]);
        acc      = bus_valid && (bus_be == '1) && (bus_addr[1:0] == 2'b00);
        do_load  = acc && bus_write && (word == W_INDEX);
        do_wdata = acc && bus_write && (word == W_MAIN || word == W_OVL);
        do_read  = acc && !bus_write;
        if (word == W_OVL)
            wsel = SEL_W'(NUM_MAIN) + SEL_W'(idx[OVL_W-1:0]);
        else
            wsel = SEL_W'(idx);
    end

    pal_seq #(.IDX_W(IDX_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .load     (do_load),
        .load_val (bus_wdata[DW-1 -: IDX_W]),
        .step     (do_wdata || do_read),
        .idx      (idx),
        .phase    (phase)
    );

    pal_store #(.NUM_MAIN(NUM_MAIN), .NUM_OVL(NUM_OVL)) u_store (
        .clk     (clk),
        .rst     (rst),
        .we      (do_wdata),
        .wsel    (wsel),
        .wphase  (phase),
        .wbyte   (bus_wdata[DW-1 -: COMP_W]),
        .rsel    (SEL_W'(idx)),
        .rrgb    (rd_rgb),
        .lut_sel (lut_idx),
        .lut_rgb (lut_c)
    );

    assign lut_rgb = lut_c;

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else if (bus_valid && !bus_write)
            bus_rdata <= do_read ? {pick(rd_rgb, phase), {(DW-COMP_W){1'b0}}} : '0;
    end

    // R7: partial byte enables leave index and phase untouched
    a_r7_partial_quiet: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_be != '1) |=> $stable(idx) && $stable(phase));

    // R7: a partial read returns zero
    a_r7_partial_rd_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write && bus_be != '1) |=> bus_rdata == '0);

    // R5: low read bits are always zero
    a_r5_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write) |=> bus_rdata[DW-COMP_W-1:0] == '0);

    // R8: unaligned accesses do not advance the sequence
    a_r8_unaligned_quiet: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_addr[1:0] != 2'b00) |=> $stable(idx) && $stable(phase));

endmodule

// File: tb/pal_ctl_bench.sv
`timescale 1ns/1ps
module pal_ctl_bench;

    localparam int NMAIN = 256;
    localparam int TOT   = 260;

    logic        clk = 0;
    logic        rst = 1;
    logic        bus_valid = 0;
    logic        bus_write = 0;
    logic [3:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [8:0]  lut_idx = '0;
    logic [23:0] lut_rgb;

    always #2 clk = ~clk;

    pal_ctl u_pal_ctl (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .lut_idx(lut_idx), .lut_rgb(lut_rgb)
    );

    int n_run = 0;
    int n_fail = 0;

    typedef struct {
        logic [31:0] v;
        string       tag;
    } exp_t;
    exp_t q[$];

    // requirement model
    logic [23:0] m_pal [TOT];
    int m_idx = 0;
    int m_ph  = 0;

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        if (m_ph == 2) begin
            m_ph  = 0;
            m_idx = (m_idx + 1) % NMAIN;
        end else begin
            m_ph++;
        end
    endtask

    task automatic do_wr(logic [3:0] off, logic [3:0] be, logic [31:0] d);
        int sel;
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = off; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_valid = 0;
        if (be == 4'hF && off[1:0] == 2'b00) begin
            if (off[3:2] == 2'd0) begin
                m_idx = d[31:24];
                m_ph  = 0;
            end else if (off[3:2] == 2'd1 || off[3:2] == 2'd3) begin
                sel = (off[3:2] == 2'd1) ? m_idx : NMAIN + (m_idx % 4);
                m_pal[sel][23 - 8*m_ph -: 8] = d[31:24];
                model_step();
            end
        end
    endtask

    task automatic do_rd(logic [3:0] off, logic [3:0] be, string tag);
        exp_t e;
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = off; bus_be = be;
        e.tag = tag;
        if (be == 4'hF && off[1:0] == 2'b00) begin
            e.v = {m_pal[m_idx][23 - 8*m_ph -: 8], 24'h0};
            model_step();
        end else begin
            e.v = '0;
        end
        q.push_back(e);
        @(negedge clk);
        bus_valid = 0;
    endtask

    task automatic lut_chk(int i, string tag);
        logic [23:0] exp;
        @(negedge clk);
        lut_idx = 9'(i);
        #1;
        exp = (i < TOT) ? m_pal[i] : 24'h0;
        chk(lut_rgb === exp, tag, {8'h0, lut_rgb}, {8'h0, exp});
    endtask

    // monitor: compare each read result against the scoreboard queue
    logic rd_fire = 0;
    always @(posedge clk) rd_fire <= bus_valid && !bus_write && !rst;
    always @(negedge clk) begin
        if (rd_fire) begin
            exp_t e;
            if (q.size() == 0) begin
                chk(0, "monitor: read with nothing expected", bus_rdata, 32'h0);
            end else begin
                e = q.pop_front();
                chk(bus_rdata === e.v, e.tag, bus_rdata, e.v);
            end
        end
    end

    initial begin
        #(4 * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < TOT; i++)
            m_pal[i] = (i == 255 || i == 256 || i == 258) ? 24'hFFFFFF : 24'h0;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: reset colours
        lut_chk(0,   "R1 entry 0");
        lut_chk(254, "R1 entry 254");
        lut_chk(255, "R1 entry 255");
        lut_chk(256, "R1 entry 256");
        lut_chk(257, "R1 entry 257");
        lut_chk(258, "R1 entry 258");
        lut_chk(259, "R1 entry 259");
        // R1 / R5: index and phase start at 0 -> read back entry 0 red, green, blue
        do_rd(4'd4, 4'hF, "R1 R5 reset read red");
        do_rd(4'd4, 4'hF, "R1 R5 reset read green");
        do_rd(4'd4, 4'hF, "R1 R5 reset read blue");

        // R2 / R3: load index 10, then stream three components (low bits ignored)
        do_wr(4'd0, 4'hF, 32'h0A00_0000);
        do_wr(4'd4, 4'hF, 32'h12AB_CDEF);
        do_wr(4'd4, 4'hF, 32'h3400_0001);
        do_wr(4'd4, 4'hF, 32'h56FF_FFFF);
        lut_chk(10, "R3 R6 entry 10 written");
        do_wr(4'd4, 4'hF, 32'h7700_0000);
        lut_chk(11, "R3 auto-increment to 11");

        // R9: reload mid-sequence restarts at red
        do_wr(4'd0, 4'hF, 32'h0B00_0000);
        do_wr(4'd4, 4'hF, 32'h8800_0000);
        do_wr(4'd4, 4'hF, 32'h9900_0000);
        do_wr(4'd4, 4'hF, 32'hAA00_0000);
        lut_chk(11, "R9 restart at red");

        // R5: readback, including a read at offset 12 (still main entry)
        do_wr(4'd0, 4'hF, 32'h0A00_0000);
        do_rd(4'd4,  4'hF, "R5 read 10 red");
        do_rd(4'd4,  4'hF, "R5 read 10 green");
        do_rd(4'd4,  4'hF, "R5 read 10 blue");
        do_rd(4'd12, 4'hF, "R5 read 11 red via offset 12");
        lut_chk(10, "R5 reads leave entry 10 unchanged");

        // R4: overlay aliasing, index 7 -> entry 259, index 5 -> entry 257
        do_wr(4'd0,  4'hF, 32'h0700_0000);
        do_wr(4'd12, 4'hF, 32'h1100_0000);
        do_wr(4'd12, 4'hF, 32'h2200_0000);
        do_wr(4'd12, 4'hF, 32'h3300_0000);
        lut_chk(259, "R4 overlay entry 259");
        lut_chk(7,   "R4 main entry 7 untouched");
        do_rd(4'd4, 4'hF, "R4 index incremented to 8");
        do_wr(4'd0,  4'hF, 32'h0500_0000);
        do_wr(4'd12, 4'hF, 32'h4400_0000);
        do_wr(4'd12, 4'hF, 32'h5500_0000);
        do_wr(4'd12, 4'hF, 32'h6600_0000);
        lut_chk(257, "R4 overlay entry 257");

        // R7: partial byte enables ignored; partial read gives 0 without advancing
        do_wr(4'd0, 4'hF, 32'h1400_0000);
        do_wr(4'd4, 4'h7, 32'hDE00_0000);
        do_wr(4'd4, 4'hF, 32'hC100_0000);
        do_rd(4'd4, 4'hE, "R7 partial read returns 0");
        do_wr(4'd4, 4'hF, 32'hC200_0000);
        do_wr(4'd4, 4'hF, 32'hC300_0000);
        lut_chk(20, "R7 partial accesses had no effect");

        // R8: control word and unaligned writes ignored
        do_wr(4'd0, 4'hF, 32'h1E00_0000);
        do_wr(4'd8, 4'hF, 32'hEE00_0000);
        do_wr(4'd5, 4'hF, 32'hEF00_0000);
        do_rd(4'd6, 4'hF, "R8 unaligned read returns 0");
        do_wr(4'd4, 4'hF, 32'hA100_0000);
        do_wr(4'd4, 4'hF, 32'hA200_0000);
        do_wr(4'd4, 4'hF, 32'hA300_0000);
        lut_chk(30, "R8 entry 30 unaffected by ignored writes");
        lut_chk(29, "R8 entry 29 untouched");

        // R3: index wrap 255 -> 0
        do_wr(4'd0, 4'hF, 32'hFF00_0000);
        do_wr(4'd4, 4'hF, 32'h0100_0000);
        do_wr(4'd4, 4'hF, 32'h0200_0000);
        do_wr(4'd4, 4'hF, 32'h0300_0000);
        do_wr(4'd4, 4'hF, 32'h4200_0000);
        lut_chk(255, "R3 entry 255 written");
        lut_chk(0,   "R3 wrap to entry 0");

        // R6: out-of-range lookups
        lut_chk(300, "R6 index 300 reads 0");
        lut_chk(511, "R6 index 511 reads 0");

        repeat (3) @(negedge clk);
        chk(q.size() == 0, "scoreboard drained", 32'(q.size()), 32'h0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule